// File: doc/BRIEF.md
# Interrupt, BRK and Reset Entry Sequencer

This block takes over the bus of an 8-bit processor with a page-one stack whenever control has to be handed to a vector: a hardware interrupt, a non-maskable interrupt, a reset or power-on, or a software break instruction. The core raises `fetch_slot` at each instruction boundary. If a request is pending at that moment, the block runs its entry sequence instead of letting an opcode be fetched. The core raises `brk_req` once it has decoded a break opcode. The block owns the program counter, the stack pointer and the status byte while it runs. The core can load all three through `core_we` whenever the block is idle.

All four entries share one walk through the same states. `ST_IDLE` waits. `ST_DUMMY0` and `ST_DUMMY1` are two thrown-away reads at the current PC (hardware entries only). `ST_STACK_HI`, `ST_STACK_LO` and `ST_STACK_P` are three stack cycles at page one. On a reset these are reads. Otherwise they are writes of PC high, PC low and status. `ST_VEC_LO` and `ST_VEC_HI` fetch the new PC from the top of memory. The transitions are:

- `ST_IDLE` goes to `ST_DUMMY0` on a taken hardware request, or to `ST_STACK_HI` on a break.
- After that, each state advances in the order listed, one state per clock.
- `ST_VEC_HI` returns to `ST_IDLE`, which hands the new PC back to opcode fetch.

The vector is chosen as the stack phase ends. Reset and power-on use their own vector. Otherwise a pending NMI redirects the entry to the NMI vector, even when the entry began as an IRQ or a break.

Top module: `entry_seq`

## Requirements
- R1: After `rst_n` is released, `seq_busy`, `bus_rd` and `bus_wr` are 0, and PC, S and status are all 0. A power-on request is pending, so the first `fetch_slot` runs the reset entry.
- R2: A hardware entry (IRQ, NMI, reset) starts with two read cycles at the current PC. No write occurs in these cycles and PC is unchanged.
- R3: For IRQ and NMI, three write cycles follow at address 0x0100+S. They carry PC[15:8], then PC[7:0], then status. S decrements by one after each cycle, wrapping modulo 256. The pushed status has bit 4 = 0 and bit 5 = 1, and its other bits equal the live status.
- R4: A break first advances PC by one, with no dummy reads. It then writes the same three bytes in the same order, with bit 4 = 1 and bit 5 = 1 in the pushed status.
- R5: Once the stack cycles end, status bit 2 (interrupt disable) is 1. With `CLR_DECIMAL`=1, bit 3 (decimal) is 0. Other status bits are kept.
- R6: The vector is read as two cycles, low byte at V and then high byte at V+1. PC becomes {data(V+1), data(V)}. V is 0xFFFE for IRQ and break, 0xFFFA for NMI, and 0xFFFC for reset.
- R7: Reset and power-on outrank NMI and IRQ. Their three stack cycles are reads at 0x0100+S with S decrementing each time, and no write at all. Starting the entry clears the pending power-on and reset requests.
- R8: A rising edge on `nmi_in` makes an NMI pending, and a held-high line does not retrigger. The pending NMI is cleared as its vector fetch begins. An NMI pending when an IRQ or break stack phase ends redirects that entry to 0xFFFA.
- R9: `irq_in` is level sensitive and ignored while status bit 2 is 1. In that case `fetch_slot` starts no entry.
- R10: `seq_busy` is 1 from the first entry cycle through the vector-high cycle, and 0 on the next cycle. `bus_rd` and `bus_wr` are never both 1. A `fetch_slot` with nothing pending starts nothing.
- R11: In `ST_IDLE`, when no entry starts, `core_we` loads PC, S and status from `core_pc`, `core_sp` and `core_p`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; raises the power-on request |
| fetch_slot | input | 1 | Core is at an instruction boundary, about to fetch an opcode |
| brk_req | input | 1 | Core has decoded a break instruction |
| irq_in | input | 1 | Maskable interrupt line, level sensitive |
| nmi_in | input | 1 | Non-maskable interrupt line, rising-edge sensitive |
| reset_req | input | 1 | Warm reset request pulse |
| core_we | input | 1 | Load PC, S and status from the core |
| core_pc | input | 16 | PC value to load |
| core_sp | input | 8 | Stack pointer value to load |
| core_p | input | 8 | Status value to load |
| bus_rdata | input | 8 | Read data for the current bus cycle |
| bus_addr | output | 16 | Bus address |
| bus_rd | output | 1 | Read cycle |
| bus_wr | output | 1 | Write cycle |
| bus_wdata | output | 8 | Write data |
| seq_busy | output | 1 | Entry sequence in progress |
| pc_out | output | 16 | Current program counter |
| sp_out | output | 8 | Current stack pointer |
| p_out | output | 8 | Current status byte |

## Verification
The assertions check several rules on every cycle:

- Writes land only in page one, and no reset entry ever writes.
- S steps down by exactly one in each stack cycle, and the second dummy read repeats the first address.
- The vector-high address follows the vector-low address, and the break bit of a pushed status matches the entry kind.
- Interrupt disable is set whenever the sequence finishes, and read and write never overlap.

Only the bench scenarios show the rest:

- Each byte pushed, and the PC loaded from the vector.
- The masking of IRQ by the interrupt-disable bit.
- The single-shot behaviour of a held NMI line, and the redirection of an IRQ or break to the NMI vector.
- The priority of reset over pending interrupts across a sweep of stack pointer and status values.

// File: rtl/entry_seq_pkg.sv
package entry_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DUMMY0,
        ST_DUMMY1,
        ST_STACK_HI,
        ST_STACK_LO,
        ST_STACK_P,
        ST_VEC_LO,
        ST_VEC_HI
    } seq_state_e;

    // Status bit positions
    localparam int FLAG_I = 2;
    localparam int FLAG_D = 3;
    localparam int FLAG_B = 4;
    localparam int FLAG_U = 5;

    // Distance of each vector below the top of the address space
    localparam int VEC_OFS_NMI = 5;
    localparam int VEC_OFS_RST = 3;
    localparam int VEC_OFS_IRQ = 1;

endpackage

// File: rtl/entry_req_track.sv
module entry_req_track (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_line,
    input  logic irq_line,
    input  logic mask_i,
    input  logic reset_line,
    input  logic clr_boot,
    input  logic clr_nmi,
    output logic por_pend,
    output logic rst_pend,
    output logic nmi_pend,
    output logic irq_live
);

    logic nmi_prev;
    logic nmi_edge;

    assign nmi_edge = nmi_line & ~nmi_prev;
    assign irq_live = irq_line & ~mask_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nmi_prev <= 1'b0;
            por_pend <= 1'b1;
            rst_pend <= 1'b0;
            nmi_pend <= 1'b0;
        end else begin
            nmi_prev <= nmi_line;
            if (clr_boot) begin
                por_pend <= 1'b0;
            end
            // A new request outranks the clear issued in the same cycle
            if (reset_line) begin
                rst_pend <= 1'b1;
            end else if (clr_boot) begin
                rst_pend <= 1'b0;
            end
            if (nmi_edge) begin
                nmi_pend <= 1'b1;
            end else if (clr_nmi) begin
                nmi_pend <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/entry_bus_mux.sv
module entry_bus_mux
    import entry_seq_pkg::*;
#(
    parameter int DW = 8,
    parameter logic [DW-1:0] STACK_PAGE = 8'h01,
    localparam int AW = 2 * DW
) (
    input  seq_state_e      state,
    input  logic [AW-1:0]   pc,
    input  logic [DW-1:0]   sp,
    input  logic [DW-1:0]   status,
    input  logic            rst_kind,
    input  logic            brk_kind,
    input  logic [AW-1:0]   vec_addr,
    output logic [AW-1:0]   bus_addr,
    output logic            bus_rd,
    output logic            bus_wr,
    output logic [DW-1:0]   bus_wdata
);

    logic [DW-1:0] pushed_status;

    always_comb begin
        pushed_status         = status;
        pushed_status[FLAG_B] = brk_kind;
        pushed_status[FLAG_U] = 1'b1;
    end

    always_comb begin
        bus_addr  = pc;
        bus_rd    = 1'b0;
        bus_wr    = 1'b0;
        bus_wdata = '0;
        unique case (state)
            ST_IDLE: begin
                bus_addr = pc;
            end
            ST_DUMMY0, ST_DUMMY1: begin
                bus_addr = pc;
                bus_rd   = 1'b1;
            end
            ST_STACK_HI: begin
                bus_addr  = {STACK_PAGE, sp};
                bus_rd    = rst_kind;
                bus_wr    = ~rst_kind;
                bus_wdata = pc[AW-1:DW];
            end
            ST_STACK_LO: begin
                bus_addr  = {STACK_PAGE, sp};
                bus_rd    = rst_kind;
                bus_wr    = ~rst_kind;
                bus_wdata = pc[DW-1:0];
            end
            ST_STACK_P: begin
                bus_addr  = {STACK_PAGE, sp};
                bus_rd    = rst_kind;
                bus_wr    = ~rst_kind;
                bus_wdata = pushed_status;
            end
            ST_VEC_LO: begin
                bus_addr = vec_addr;
                bus_rd   = 1'b1;
            end
            ST_VEC_HI: begin
                bus_addr = vec_addr | AW'(1);
                bus_rd   = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/entry_seq.sv
module entry_seq
    import entry_seq_pkg::*;
#(
    parameter int DW = 8,
    parameter logic [DW-1:0] STACK_PAGE = 8'h01,
    parameter bit CLR_DECIMAL = 1'b1,
    localparam int AW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fetch_slot,
    input  logic          brk_req,
    input  logic          irq_in,
    input  logic          nmi_in,
    input  logic          reset_req,
    input  logic          core_we,
    input  logic [AW-1:0] core_pc,
    input  logic [DW-1:0] core_sp,
    input  logic [DW-1:0] core_p,
    input  logic [DW-1:0] bus_rdata,
    output logic [AW-1:0] bus_addr,
    output logic          bus_rd,
    output logic          bus_wr,
    output logic [DW-1:0] bus_wdata,
    output logic          seq_busy,
    output logic [AW-1:0] pc_out,
    output logic [DW-1:0] sp_out,
    output logic [DW-1:0] p_out
);

    localparam logic [AW-1:0] ADDR_TOP = '1;
    localparam logic [AW-1:0] VEC_NMI  = ADDR_TOP - AW'(VEC_OFS_NMI);
    localparam logic [AW-1:0] VEC_RST  = ADDR_TOP - AW'(VEC_OFS_RST);
    localparam logic [AW-1:0] VEC_IRQ  = ADDR_TOP - AW'(VEC_OFS_IRQ);

    seq_state_e    state_q, state_d;
    logic [AW-1:0] pc_q;
    logic [DW-1:0] sp_q;
    logic [DW-1:0] p_q;
    logic [AW-1:0] vec_q;
    logic          rst_kind_q;
    logic          brk_kind_q;

    logic por_pend, rst_pend, nmi_pend, irq_live;
    logic any_pend, boot_pend;
    logic take_hw, take_brk, clr_nmi, stack_cycle;

    entry_req_track u_req (
        .clk        (clk),
        .rst_n      (rst_n),
        .nmi_line   (nmi_in),
        .irq_line   (irq_in),
        .mask_i     (p_q[FLAG_I]),
        .reset_line (reset_req),
        .clr_boot   (take_hw && boot_pend),
        .clr_nmi    (clr_nmi),
        .por_pend   (por_pend),
        .rst_pend   (rst_pend),
        .nmi_pend   (nmi_pend),
        .irq_live   (irq_live)
    );

    assign boot_pend   = por_pend | rst_pend;
    assign any_pend    = boot_pend | nmi_pend | irq_live;
    assign take_hw     = (state_q == ST_IDLE) && fetch_slot && any_pend;
    assign take_brk    = (state_q == ST_IDLE) && !take_hw && brk_req;
    assign clr_nmi     = (state_q == ST_STACK_P) && !rst_kind_q && nmi_pend;
    assign stack_cycle = (state_q == ST_STACK_HI) || (state_q == ST_STACK_LO)
                       || (state_q == ST_STACK_P);

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (take_hw) begin
                    state_d = ST_DUMMY0;
                end else if (take_brk) begin
                    state_d = ST_STACK_HI;
                end
            end
            ST_DUMMY0:   state_d = ST_DUMMY1;
            ST_DUMMY1:   state_d = ST_STACK_HI;
            ST_STACK_HI: state_d = ST_STACK_LO;
            ST_STACK_LO: state_d = ST_STACK_P;
            ST_STACK_P:  state_d = ST_VEC_LO;
            ST_VEC_LO:   state_d = ST_VEC_HI;
            ST_VEC_HI:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Architectural registers touched by the sequence
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q       <= '0;
            sp_q       <= '0;
            p_q        <= '0;
            vec_q      <= VEC_RST;
            rst_kind_q <= 1'b0;
            brk_kind_q <= 1'b0;
        end else begin
            if (take_hw) begin
                rst_kind_q <= boot_pend;
                brk_kind_q <= 1'b0;
            end else if (take_brk) begin
                rst_kind_q <= 1'b0;
                brk_kind_q <= 1'b1;
                pc_q       <= pc_q + AW'(1);
            end else if ((state_q == ST_IDLE) && core_we) begin
                pc_q <= core_pc;
                sp_q <= core_sp;
                p_q  <= core_p;
            end

            if (stack_cycle) begin
                sp_q <= sp_q - DW'(1);
            end

            if (state_q == ST_STACK_P) begin
                p_q[FLAG_I] <= 1'b1;
                if (CLR_DECIMAL) begin
                    p_q[FLAG_D] <= 1'b0;
                end
                if (rst_kind_q) begin
                    vec_q <= VEC_RST;
                end else if (nmi_pend) begin
                    vec_q <= VEC_NMI;
                end else begin
                    vec_q <= VEC_IRQ;
                end
            end

            if (state_q == ST_VEC_LO) begin
                pc_q[DW-1:0] <= bus_rdata;
            end
            if (state_q == ST_VEC_HI) begin
                pc_q[AW-1:DW] <= bus_rdata;
            end
        end
    end

    // Bus outputs
    entry_bus_mux #(
        .DW         (DW),
        .STACK_PAGE (STACK_PAGE)
    ) u_bus (
        .state     (state_q),
        .pc        (pc_q),
        .sp        (sp_q),
        .status    (p_q),
        .rst_kind  (rst_kind_q),
        .brk_kind  (brk_kind_q),
        .vec_addr  (vec_q),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata)
    );

    assign seq_busy = (state_q != ST_IDLE);
    assign pc_out   = pc_q;
    assign sp_out   = sp_q;
    assign p_out    = p_q;

endmodule

// File: rtl/entry_seq_checker.sv
module entry_seq_checker
    import entry_seq_pkg::*;
#(
    parameter int DW = 8,
    parameter logic [DW-1:0] STACK_PAGE = 8'h01,
    localparam int AW = 2 * DW
) (
    input logic          clk,
    input logic          rst_n,
    input seq_state_e    state_q,
    input logic          rst_kind_q,
    input logic          brk_kind_q,
    input logic [AW-1:0] bus_addr,
    input logic          bus_rd,
    input logic          bus_wr,
    input logic [DW-1:0] bus_wdata,
    input logic          seq_busy,
    input logic [DW-1:0] sp_out,
    input logic [DW-1:0] p_out
);

    p_wr_in_stack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> (bus_addr[AW-1:DW] == STACK_PAGE));

    p_sp_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STACK_HI || state_q == ST_STACK_LO || state_q == ST_STACK_P)
        |=> (sp_out == $past(sp_out) - DW'(1)));

    p_dummy_repeat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DUMMY0) |=> (bus_rd && !bus_wr && bus_addr == $past(bus_addr)));

    p_break_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && state_q == ST_STACK_P)
        |-> (bus_wdata[FLAG_B] == brk_kind_q && bus_wdata[FLAG_U]));

    p_mask_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(seq_busy) |-> p_out[FLAG_I]);

    p_vec_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_VEC_LO) |=> (bus_rd && bus_addr == $past(bus_addr) + AW'(1)));

    p_reset_reads_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_busy && rst_kind_q) |-> !bus_wr);

    p_rd_wr_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));

endmodule

bind entry_seq entry_seq_checker #(
    .DW         (DW),
    .STACK_PAGE (STACK_PAGE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .state_q    (state_q),
    .rst_kind_q (rst_kind_q),
    .brk_kind_q (brk_kind_q),
    .bus_addr   (bus_addr),
    .bus_rd     (bus_rd),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .seq_busy   (seq_busy),
    .sp_out     (sp_out),
    .p_out      (p_out)
);

// File: tb/sim_entry_seq.sv
module sim_entry_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_slot = 1'b0, brk_req = 1'b0, irq_in = 1'b0, nmi_in = 1'b0;
    logic        reset_req = 1'b0, core_we = 1'b0;
    logic [15:0] core_pc = '0;
    logic [7:0]  core_sp = '0, core_p = '0;
    logic [7:0]  bus_rdata;
    logic [15:0] bus_addr, pc_out;
    logic        bus_rd, bus_wr, seq_busy;
    logic [7:0]  bus_wdata, sp_out, p_out;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    entry_seq #(.DW(8), .STACK_PAGE(8'h01), .CLR_DECIMAL(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .fetch_slot(fetch_slot), .brk_req(brk_req),
        .irq_in(irq_in), .nmi_in(nmi_in), .reset_req(reset_req),
        .core_we(core_we), .core_pc(core_pc), .core_sp(core_sp), .core_p(core_p),
        .bus_rdata(bus_rdata), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .seq_busy(seq_busy), .pc_out(pc_out),
        .sp_out(sp_out), .p_out(p_out)
    );

    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    always_comb bus_rdata = mem_byte(bus_addr);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_cycle(input string tag, input logic [15:0] a, input logic rd,
                             input logic wr, input logic [7:0] wd);
        check({tag, " addr"}, {16'h0, bus_addr}, {16'h0, a});
        check({tag, " rd/wr"}, {30'h0, bus_rd, bus_wr}, {30'h0, rd, wr});
        check({tag, " busy"}, {31'h0, seq_busy}, 32'h1);
        if (wr) check({tag, " wdata"}, {24'h0, bus_wdata}, {24'h0, wd});
        @(negedge clk);
    endtask

    // Called at the negedge inside the first entry cycle
    task automatic expect_entry(input bit is_rst, input bit is_brk, input bit nmi_vec,
                                input logic [15:0] pc0, input logic [7:0] sp0,
                                input logic [7:0] p0);
        logic [15:0] pc1, v;
        logic [7:0] ps, pexp;
        if (!is_brk) begin
            bus_cycle("R2 dummy0", pc0, 1'b1, 1'b0, 8'h00);
            bus_cycle("R2 dummy1", pc0, 1'b1, 1'b0, 8'h00);
        end
        pc1 = is_brk ? pc0 + 16'd1 : pc0;
        ps = (p0 & 8'hEF) | 8'h20 | (is_brk ? 8'h10 : 8'h00);
        if (is_rst) begin
            bus_cycle("R7 stack read0", {8'h01, sp0},         1'b1, 1'b0, 8'h00);
            bus_cycle("R7 stack read1", {8'h01, sp0 - 8'd1}, 1'b1, 1'b0, 8'h00);
            bus_cycle("R7 stack read2", {8'h01, sp0 - 8'd2}, 1'b1, 1'b0, 8'h00);
        end else begin
            bus_cycle(is_brk ? "R4 push pch" : "R3 push pch", {8'h01, sp0}, 1'b0, 1'b1, pc1[15:8]);
            bus_cycle(is_brk ? "R4 push pcl" : "R3 push pcl", {8'h01, sp0 - 8'd1}, 1'b0, 1'b1, pc1[7:0]);
            bus_cycle(is_brk ? "R4 push p" : "R3 push p", {8'h01, sp0 - 8'd2}, 1'b0, 1'b1, ps);
        end
        v = is_rst ? 16'hFFFC : (nmi_vec ? 16'hFFFA : 16'hFFFE);
        bus_cycle(nmi_vec ? "R8 vec lo" : "R6 vec lo", v, 1'b1, 1'b0, 8'h00);
        bus_cycle(nmi_vec ? "R8 vec hi" : "R6 vec hi", v + 16'd1, 1'b1, 1'b0, 8'h00);
        check("R10 busy drops", {31'h0, seq_busy}, 32'h0);
        check("R6 new pc", {16'h0, pc_out}, {16'h0, mem_byte(v + 16'd1), mem_byte(v)});
        check("R3 final sp", {24'h0, sp_out}, {24'h0, sp0 - 8'd3});
        pexp = (p0 | 8'h04) & 8'hF7;
        check("R5 status", {24'h0, p_out}, {24'h0, pexp});
    endtask

    task automatic pulse_fetch();
        fetch_slot = 1'b1;
        @(negedge clk);
        fetch_slot = 1'b0;
    endtask

    task automatic pulse_brk();
        brk_req = 1'b1;
        @(negedge clk);
        brk_req = 1'b0;
    endtask

    task automatic pulse_nmi();
        nmi_in = 1'b1;
        @(negedge clk);
        nmi_in = 1'b0;
        @(negedge clk);
    endtask

    task automatic core_load(input logic [15:0] pc, input logic [7:0] sp, input logic [7:0] p);
        core_pc = pc; core_sp = sp; core_p = p; core_we = 1'b1;
        @(negedge clk);
        core_we = 1'b0;
        check("R11 load pc", {16'h0, pc_out}, {16'h0, pc});
        check("R11 load sp", {24'h0, sp_out}, {24'h0, sp});
        check("R11 load p", {24'h0, p_out}, {24'h0, p});
    endtask

    task automatic expect_no_entry(input string tag);
        pulse_fetch();
        check(tag, {31'h0, seq_busy}, 32'h0);
        @(negedge clk);
        check(tag, {31'h0, seq_busy}, 32'h0);
    endtask

    initial begin
        logic [7:0] sp_list [6];
        logic [7:0] p_list [2];
        logic [15:0] pc_keep;
        sp_list = '{8'h00, 8'h01, 8'h02, 8'h7F, 8'h80, 8'hFF};
        p_list  = '{8'h08, 8'hC3};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy", {31'h0, seq_busy}, 32'h0);
        check("R1 rd/wr", {30'h0, bus_rd, bus_wr}, 32'h0);
        check("R1 pc", {16'h0, pc_out}, 32'h0);
        check("R1 sp", {24'h0, sp_out}, 32'h0);
        check("R1 p", {24'h0, p_out}, 32'h0);

        // R1 / R7: power-on entry on first boundary
        pulse_fetch();
        expect_entry(1'b1, 1'b0, 1'b0, 16'h0000, 8'h00, 8'h00);

        // R10: nothing pending
        pc_keep = pc_out;
        expect_no_entry("R10 idle fetch");
        check("R10 pc kept", {16'h0, pc_out}, {16'h0, pc_keep});

        // R9: IRQ masked by I
        irq_in = 1'b1;
        expect_no_entry("R9 masked irq");
        irq_in = 1'b0;

        // Sweep stack pointer, status and entry kind
        for (int s = 0; s < 6; s++) begin
            for (int q = 0; q < 2; q++) begin
                for (int k = 0; k < 3; k++) begin
                    logic [15:0] pc0;
                    pc0 = 16'h1234 + 16'(s * 16'h0101) + 16'(k * 7) + 16'(q);
                    core_load(pc0, sp_list[s], p_list[q]);
                    if (k == 0) begin
                        irq_in = 1'b1;
                        pulse_fetch();
                        irq_in = 1'b0;
                        expect_entry(1'b0, 1'b0, 1'b0, pc0, sp_list[s], p_list[q]);
                    end else if (k == 1) begin
                        pulse_nmi();
                        pulse_fetch();
                        expect_entry(1'b0, 1'b0, 1'b1, pc0, sp_list[s], p_list[q]);
                        expect_no_entry("R8 nmi cleared");
                    end else begin
                        pulse_brk();
                        expect_entry(1'b0, 1'b1, 1'b0, pc0, sp_list[s], p_list[q]);
                    end
                end
            end
        end

        // R8: held-high NMI fires once
        core_load(16'h4000, 8'hF0, 8'h00);
        nmi_in = 1'b1;
        @(negedge clk);
        pulse_fetch();
        expect_entry(1'b0, 1'b0, 1'b1, 16'h4000, 8'hF0, 8'h00);
        expect_no_entry("R8 held nmi no retrigger");
        nmi_in = 1'b0;
        @(negedge clk);

        // R8: NMI arriving with a break redirects it
        core_load(16'h5000, 8'hE0, 8'h01);
        nmi_in = 1'b1;
        pulse_brk();
        nmi_in = 1'b0;
        expect_entry(1'b0, 1'b1, 1'b1, 16'h5000, 8'hE0, 8'h01);

        // R8: NMI arriving with an IRQ redirects it
        core_load(16'h6000, 8'hD0, 8'h00);
        irq_in = 1'b1;
        nmi_in = 1'b1;
        pulse_fetch();
        irq_in = 1'b0;
        nmi_in = 1'b0;
        expect_entry(1'b0, 1'b0, 1'b1, 16'h6000, 8'hD0, 8'h00);

        // R7: warm reset outranks pending NMI and IRQ; NMI survives
        core_load(16'hABCD, 8'h42, 8'h0B);
        reset_req = 1'b1;
        nmi_in = 1'b1;
        @(negedge clk);
        reset_req = 1'b0;
        nmi_in = 1'b0;
        irq_in = 1'b1;
        pulse_fetch();
        irq_in = 1'b0;
        expect_entry(1'b1, 1'b0, 1'b0, 16'hABCD, 8'h42, 8'h0B);
        pc_keep = pc_out;
        pulse_fetch();
        expect_entry(1'b0, 1'b0, 1'b1, pc_keep, 8'h3F, 8'h07);
        expect_no_entry("R7 reset request cleared");

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        finished = 1'b1;
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

endmodule